// File: doc/BRIEF.md
# Single-Port RAM Queue with Pointer Comparator

This block is a first-in-first-out queue built on one single-port synchronous RAM of 1024 words. Two wrapping counters track the queue. The fill pointer names the slot that the next write takes. The drain pointer names the oldest stored word. An address selector gives the RAM port to the fill pointer on a write and to the drain pointer on a read. Only one operation runs in a cycle.

A comparator looks at the two pointers and reports the ordering of their low bits and whether their wrap bits differ. The empty and full flags come from that result. A user raises `enable`, uses `rdWrSel` to choose a write (1) or a read (0), and collects read data from the registered output on the following clock.

Top module: `ramq_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears both pointers and `rdData`. After reset, `empty`=1, `full`=0 and `rdData`=0.
- R2: A cycle with `enable`=0 changes nothing. `empty`, `full` and `rdData` hold, and the stored contents and their order stay intact whatever `rdWrSel` and `wrData` carry.
- R3: A cycle with `enable`=1 and `rdWrSel`=1 is a write that appends `wrData`. A cycle with `enable`=1 and `rdWrSel`=0 is a read that removes the oldest word. Words leave in the order they arrived.
- R4: The word removed by a read appears on `rdData` one clock after the edge that accepts the read. `rdData` then holds through writes and idle cycles until the next accepted read.
- R5: `empty` is 1 exactly when no word is stored. `full` is 1 exactly when 1024 words are stored. The two flags are never 1 together.
- R6: A write while `full`=1 is ignored. Nothing is stored, `full` stays 1, and `rdData` holds.
- R7: A read while `empty`=1 is ignored. `rdData` holds and `empty` stays 1.
- R8: Order and contents stay correct after either pointer passes slot 1023 and wraps to slot 0, across many such wraps.
- R9: One accepted read from a full queue clears `full` at the next edge. One accepted write to an empty queue clears `empty` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Operation request for this cycle |
| rdWrSel | input | 1 | 1 selects a write, 0 selects a read |
| wrData | input | DATA_W | Word to append on a write |
| rdData | output | DATA_W | Registered word removed by the last accepted read |
| empty | output | 1 | No word stored |
| full | output | 1 | All 1024 slots occupied |

## Verification
The bench fills the queue to exactly 1024 words and checks that `full` first rises on the last write. If the wrap bit is dropped or the comparator is miswired, `full` rises early, `full` never rises, or `empty` is flagged instead. The bench pushes writes into a full queue and reads from an empty one. A design without those guards would overwrite the oldest word or move the drain pointer past the fill pointer, and the bench sees this as wrong data or a wrong word count on drain. Several thousand mixed operations carry both pointers around the RAM more than once, which exposes a wrong address selection or a broken wrap. Idle cycles with noisy inputs expose any path that stores or advances without `enable`.

// File: rtl/ramq_pkg.sv
package ramq_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic cs;       // RAM port active this cycle
    logic wr;       // 1 = write, 0 = read
    logic selBack;  // address from drain pointer
  } memCtl_t;

  // ordering of the low pointer bits
  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2
  } ptrRel_e;

endpackage

// File: rtl/ramq_cmp.sv
module ramq_cmp #(
  parameter int ADDR_W = 10,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic [PTR_W-1:0] frontPtr,
  input  logic [PTR_W-1:0] backPtr,
  output ramq_pkg::ptrRel_e rel,
  output logic             wrapDiff
);
  import ramq_pkg::*;

  always_comb begin
    if (frontPtr[ADDR_W-1:0] < backPtr[ADDR_W-1:0])      rel = REL_LT;
    else if (frontPtr[ADDR_W-1:0] > backPtr[ADDR_W-1:0]) rel = REL_GT;
    else                                                 rel = REL_EQ;
  end

  assign wrapDiff = frontPtr[ADDR_W] ^ backPtr[ADDR_W];

endmodule

// File: rtl/ramq_ctrl.sv
module ramq_ctrl #(
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 rdWrSel,
  output ramq_pkg::memCtl_t    memCtl,
  output logic [ADDR_W-1:0]    frontAddr,
  output logic [ADDR_W-1:0]    backAddr,
  output logic                 empty,
  output logic                 full
);
  import ramq_pkg::*;

  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] frontPtr, backPtr;
  ptrRel_e          rel;
  logic             wrapDiff;
  logic             wrGo, rdGo;

  ramq_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .frontPtr(frontPtr),
    .backPtr (backPtr),
    .rel     (rel),
    .wrapDiff(wrapDiff)
  );

  assign empty = (rel == REL_EQ) && !wrapDiff;
  assign full  = (rel == REL_EQ) &&  wrapDiff;

  assign wrGo = enable &&  rdWrSel && !full;
  assign rdGo = enable && !rdWrSel && !empty;

  always_comb begin
    memCtl.cs      = wrGo || rdGo;
    memCtl.wr      = wrGo;
    memCtl.selBack = rdGo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frontPtr <= '0;
      backPtr  <= '0;
    end else begin
      if (wrGo) frontPtr <= frontPtr + 1'b1;
      if (rdGo) backPtr  <= backPtr + 1'b1;
    end
  end

  assign frontAddr = frontPtr[ADDR_W-1:0];
  assign backAddr  = backPtr[ADDR_W-1:0];

endmodule

// File: rtl/ramq_datapath.sv
module ramq_datapath #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ramq_pkg::memCtl_t memCtl,
  input  logic [ADDR_W-1:0] frontAddr,
  input  logic [ADDR_W-1:0] backAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr;

  // address selector: single shared port
  assign addr = memCtl.selBack ? backAddr : frontAddr;

  always_ff @(posedge clk) begin
    if (memCtl.cs && memCtl.wr) mem[addr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)                         rdData <= '0;
    else if (memCtl.cs && !memCtl.wr) rdData <= mem[addr];
  end

endmodule

// File: rtl/ramq_fifo.sv
module ramq_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              rdWrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              full
);
  import ramq_pkg::*;

  memCtl_t           memCtl;
  logic [ADDR_W-1:0] frontAddr, backAddr;

  ramq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .rdWrSel  (rdWrSel),
    .memCtl   (memCtl),
    .frontAddr(frontAddr),
    .backAddr (backAddr),
    .empty    (empty),
    .full     (full)
  );

  ramq_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .memCtl   (memCtl),
    .frontAddr(frontAddr),
    .backAddr (backAddr),
    .wrData   (wrData),
    .rdData   (rdData)
  );

endmodule

// File: rtl/ramq_fifo_chk.sv
module ramq_fifo_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              rdWrSel,
  input logic [DATA_W-1:0] rdData,
  input logic              empty,
  input logic              full
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (empty && !full && rdData == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> ($stable(rdData) && $stable(empty) && $stable(full)));

  // R4
  write_keeps_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && rdWrSel) |=> $stable(rdData));

  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && rdWrSel && full) |=> (full && $stable(rdData)));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !rdWrSel && empty) |=> (empty && $stable(rdData)));

  // R9
  full_release_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !rdWrSel && full) |=> !full);

  // R9
  empty_release_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && rdWrSel && empty) |=> !empty);

endmodule

bind ramq_fifo ramq_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .enable (enable),
  .rdWrSel(rdWrSel),
  .rdData (rdData),
  .empty  (empty),
  .full   (full)
);

// File: tb/ramq_fifo_tb.sv
module ramq_fifo_tb;
  localparam int DW    = 8;
  localparam int DEPTH = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          rdWrSel = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          empty, full;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [$];
  logic [DW-1:0] expRd = '0;

  always #4 clk = ~clk;

  ramq_fifo #(.DATA_W(DW), .ADDR_W(10)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .rdWrSel(rdWrSel),
    .wrData(wrData), .rdData(rdData), .empty(empty), .full(full)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag);
    check(rdData == expRd, {tag, " rdData"}, int'(rdData), int'(expRd));
    check(empty == (model.size() == 0), {tag, " empty"}, int'(empty), int'(model.size() == 0));
    check(full == (model.size() == DEPTH), {tag, " full"}, int'(full), int'(model.size() == DEPTH));
  endtask

  // each op starts at a falling edge and ends at the next one
  task automatic doWrite(input logic [DW-1:0] d, input string tag);
    bit ok;
    ok = model.size() < DEPTH;
    enable = 1'b1; rdWrSel = 1'b1; wrData = d;
    @(negedge clk);
    if (ok) model.push_back(d);
    checkState(tag);
  endtask

  task automatic doRead(input string tag);
    bit ok;
    ok = model.size() > 0;
    enable = 1'b1; rdWrSel = 1'b0; wrData = 8'h5A;
    @(negedge clk);
    if (ok) expRd = model.pop_front();
    checkState(tag);
  endtask

  task automatic doIdle(input logic sel, input logic [DW-1:0] d, input string tag);
    enable = 1'b0; rdWrSel = sel; wrData = d;
    @(negedge clk);
    checkState(tag);
  endtask

  task automatic testReset();
    checkState("R1 reset");
  endtask

  task automatic testEmptyRead();
    doRead("R7 read empty");
    doRead("R7 read empty again");
  endtask

  task automatic testBasic();
    doWrite(8'h11, "R9 first write clears empty");
    doWrite(8'h22, "R3 write");
    doWrite(8'h33, "R3 write");
    doRead("R3 R4 read oldest");
    doIdle(1'b0, 8'h00, "R4 hold idle");
    doWrite(8'h44, "R4 hold across write");
    doRead("R3 read order");
    doRead("R3 read order");
    doRead("R3 read last");
    doRead("R7 read after drain");
  endtask

  task automatic testIdle();
    doWrite(8'hA1, "R2 setup");
    doWrite(8'hA2, "R2 setup");
    for (int i = 0; i < 6; i++) doIdle(i[0], 8'hF0 + 8'(i), "R2 idle noise");
    doRead("R2 content intact");
    doRead("R2 content intact");
    doIdle(1'b1, 8'hFF, "R2 idle when empty");
  endtask

  task automatic testFull();
    for (int i = 0; i < DEPTH; i++) begin
      doWrite(8'(i * 7 + 3), "R5 fill");
      if (i == DEPTH - 2) check(!full, "R5 not full at 1023", int'(full), 0);
    end
    check(full, "R5 full at 1024", int'(full), 1);
    doWrite(8'hEE, "R6 write when full");
    doWrite(8'hED, "R6 write when full");
    doRead("R9 read clears full");
    doWrite(8'hC7, "R5 refill");
    check(full, "R5 full again", int'(full), 1);
    for (int i = 0; i < DEPTH; i++) doRead("R6 drain no stray word");
    check(empty, "R5 empty after drain", int'(empty), 1);
    doRead("R7 read empty after drain");
  endtask

  task automatic testWrap();
    int seed = 17;
    for (int round = 0; round < 8; round++) begin
      for (int i = 0; i < 300; i++) begin
        seed = seed * 1103 + 12345;
        doWrite(8'(seed >>> 8), "R8 wrap write");
      end
      for (int i = 0; i < 250; i++) doRead("R8 wrap read");
    end
    while (model.size() > 0) doRead("R8 wrap drain");
    check(empty, "R8 empty at end", int'(empty), 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: act=%0d exp=0", checks);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testEmptyRead();
    testBasic();
    testIdle();
    testFull();
    testWrap();
    enable = 1'b0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule